// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the 6-bit operand field of a 16-bit, word-addressed processor into an effective operand. The operand can be a register, a memory word, or a literal value. It takes the operand code together with the eight general registers, the stack pointer, the program counter, the overflow register and the instruction word that follows the current one. From these it produces the operand selection, the memory address or the operand value, the stack pointer and program counter after the operand's side effects, and the extra cycle cost.

The stack pointer and the program counter are ordinary operands. Push, pop and peek are addressing modes, and a write to the program counter acts as a jump. Both kinds of side effect therefore leave this block rather than a dedicated instruction.

Decode is registered. The outputs update on the rising clock edge at which `dec_i` is high, and they hold otherwise. The core pulses `wr_i` while the decoded result is on the outputs. The block then steers that write to exactly one destination, or to none when the operand is a literal.

Top module: `opd_decoder`

## Requirements
- R1: After reset, and before the first decode, the outputs are: sel_o=2 (literal), tgt_o=0, addr_o=0, val_o=0, sp_o=0, pc_o=0 and cost_o=0. All write enables are low while wr_i is low.
- R2: Codes 0x00..0x07 give sel_o=0 (register), tgt_o equal to the code and val_o equal to that general register. Code 0x1b gives tgt_o=8 with val_o=SP, code 0x1c gives tgt_o=9 with val_o=PC, and code 0x1d gives tgt_o=10 with val_o=EX. In every case sel_o=0.
- R3: Codes 0x08..0x0f give sel_o=1 (memory) and addr_o equal to general register (code−8).
- R4: Codes 0x10..0x17 give sel_o=1 and addr_o = next word + register (code−16), modulo 2^16. They also give pc_o=PC+1 and cost_o=1.
- R5: Code 0x18 (pop) gives sel_o=1, addr_o=SP and sp_o=SP+1. Code 0x19 (peek) gives addr_o=SP with sp_o=SP. Code 0x1a (push) gives addr_o=SP−1 and sp_o=SP−1. All of these wrap modulo 2^16.
- R6: Code 0x1e gives sel_o=1 with addr_o equal to the next word. Code 0x1f gives sel_o=2 with val_o equal to the next word. Both give pc_o=PC+1 and cost_o=1.
- R7: Codes 0x20..0x3f give sel_o=2 and val_o=code−0x20, covering the values 0..31.
- R8: Codes that do not use the next word give pc_o=PC and cost_o=0. Codes other than pop and push give sp_o=SP.
- R9: With wr_i high, each decoded target raises exactly one enable. General register n raises bit n of wr_gpr_o. Target 8 raises wr_sp_o, target 9 raises wr_pc_o and target 10 raises wr_ex_o. A memory operand raises wr_mem_o. A literal raises no enable.
- R10: While dec_i is low, every decode output holds its value regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_i | input | 1 | Decode strobe; captures a new operand |
| code_i | input | 6 | Operand code |
| regs_i | input | 128 | Eight general registers, register n at bits [16n+15:16n] |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | PC, already pointing at the word after the current instruction |
| ex_i | input | 16 | Overflow register |
| nw_i | input | 16 | Next instruction word |
| wr_i | input | 1 | Write request for the decoded operand |
| sel_o | output | 2 | 0 register, 1 memory, 2 literal |
| tgt_o | output | 4 | Register target: 0..7 general, 8 SP, 9 PC, 10 EX |
| addr_o | output | 16 | Memory address of a memory operand |
| val_o | output | 16 | Value of a register or literal operand |
| sp_o | output | 16 | Stack pointer after side effects |
| pc_o | output | 16 | Program counter after next-word fetch |
| cost_o | output | 2 | Extra cycles spent by this operand |
| wr_gpr_o | output | 8 | Write enable per general register |
| wr_sp_o | output | 1 | Write enable for SP |
| wr_pc_o | output | 1 | Write enable for PC (jump) |
| wr_ex_o | output | 1 | Write enable for EX |
| wr_mem_o | output | 1 | Write enable for memory at addr_o |

## Verification
Every code in each group is decoded, and each general register holds a distinct value. A swapped register index or a shifted group boundary therefore shows up as a wrong value or address, not as a coincidental match. Two cases probe the modulo-2^16 arithmetic: next-word-plus-register sums that wrap, and push at SP=0 and pop at SP=0xFFFF. The same two cases separate correct pre-decrement and post-increment ordering from reversed ordering. A push followed by a pop through a small bench memory shows that the two modes address the same word. Write steering is driven for each target class, including literals, so a write that leaks to a wrong or extra enable is caught. A hold case changes every input while dec_i is low.

// File: rtl/opd_pkg.sv
package opd_pkg;
  typedef enum logic [1:0] {SEL_REG = 2'd0, SEL_MEM = 2'd1, SEL_LIT = 2'd2} sel_e;
  typedef enum logic [1:0] {SP_KEEP = 2'd0, SP_INC = 2'd1, SP_DEC = 2'd2} spop_e;
  typedef enum logic [1:0] {AB_ZERO = 2'd0, AB_REG = 2'd1, AB_SP = 2'd2, AB_SPM1 = 2'd3} abase_e;

  localparam logic [3:0] TGT_SP = 4'd8;
  localparam logic [3:0] TGT_PC = 4'd9;
  localparam logic [3:0] TGT_EX = 4'd10;

  typedef struct packed {
    sel_e       sel;
    logic [3:0] tgt;
    logic       use_nw;
    spop_e      spop;
    abase_e     abase;
  } ctl_t;
endpackage

// File: rtl/opd_classify.sv
module opd_classify
  import opd_pkg::*;
(
  input  logic [5:0] code_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '{sel: SEL_LIT, tgt: 4'd0, use_nw: 1'b0, spop: SP_KEEP, abase: AB_ZERO};
    if (!code_i[5]) begin
      unique case (code_i[4:3])
        2'b00: begin
          ctl_o.sel = SEL_REG;
          ctl_o.tgt = {1'b0, code_i[2:0]};
        end
        2'b01: begin
          ctl_o.sel   = SEL_MEM;
          ctl_o.abase = AB_REG;
        end
        2'b10: begin
          ctl_o.sel    = SEL_MEM;
          ctl_o.abase  = AB_REG;
          ctl_o.use_nw = 1'b1;
        end
        default: begin
          unique case (code_i[2:0])
            3'd0: begin ctl_o.sel = SEL_MEM; ctl_o.abase = AB_SP;   ctl_o.spop = SP_INC; end
            3'd1: begin ctl_o.sel = SEL_MEM; ctl_o.abase = AB_SP;   end
            3'd2: begin ctl_o.sel = SEL_MEM; ctl_o.abase = AB_SPM1; ctl_o.spop = SP_DEC; end
            3'd3: begin ctl_o.sel = SEL_REG; ctl_o.tgt = TGT_SP; end
            3'd4: begin ctl_o.sel = SEL_REG; ctl_o.tgt = TGT_PC; end
            3'd5: begin ctl_o.sel = SEL_REG; ctl_o.tgt = TGT_EX; end
            3'd6: begin ctl_o.sel = SEL_MEM; ctl_o.use_nw = 1'b1; end
            default: ctl_o.use_nw = 1'b1;  // next word as literal
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/opd_eval.sv
module opd_eval
  import opd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int CW   = 2
) (
  input  ctl_t               ctl_i,
  input  logic [4:0]         code_lo_i,
  input  logic [NREG*DW-1:0] regs_i,
  input  logic [DW-1:0]      sp_i,
  input  logic [DW-1:0]      pc_i,
  input  logic [DW-1:0]      ex_i,
  input  logic [DW-1:0]      nw_i,
  output logic [DW-1:0]      addr_o,
  output logic [DW-1:0]      val_o,
  output logic [DW-1:0]      sp_o,
  output logic [DW-1:0]      pc_o,
  output logic [CW-1:0]      cost_o
);
  localparam int RIW = $clog2(NREG);

  logic [DW-1:0] base, idx_reg, tgt_reg, short_lit;

  assign idx_reg   = regs_i[int'(code_lo_i[RIW-1:0])*DW +: DW];
  assign tgt_reg   = regs_i[int'(ctl_i.tgt[RIW-1:0])*DW +: DW];
  assign short_lit = {{(DW-5){1'b0}}, code_lo_i};

  always_comb begin
    unique case (ctl_i.abase)
      AB_REG:  base = idx_reg;
      AB_SP:   base = sp_i;
      AB_SPM1: base = sp_i - 1'b1;
      default: base = '0;
    endcase
  end

  assign addr_o = (ctl_i.sel == SEL_MEM && ctl_i.use_nw) ? base + nw_i : base;

  always_comb begin
    if (ctl_i.sel == SEL_REG) begin
      unique case (ctl_i.tgt)
        TGT_SP:  val_o = sp_i;
        TGT_PC:  val_o = pc_i;
        TGT_EX:  val_o = ex_i;
        default: val_o = tgt_reg;
      endcase
    end else if (ctl_i.sel == SEL_LIT) begin
      val_o = ctl_i.use_nw ? nw_i : short_lit;
    end else begin
      val_o = '0;
    end
  end

  always_comb begin
    unique case (ctl_i.spop)
      SP_INC:  sp_o = sp_i + 1'b1;
      SP_DEC:  sp_o = sp_i - 1'b1;
      default: sp_o = sp_i;
    endcase
  end

  assign pc_o   = ctl_i.use_nw ? pc_i + 1'b1 : pc_i;
  assign cost_o = ctl_i.use_nw ? CW'(1) : '0;
endmodule

// File: rtl/opd_wsteer.sv
module opd_wsteer
  import opd_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [1:0]      sel_i,
  input  logic [3:0]      tgt_i,
  output logic [NREG-1:0] wr_gpr_o,
  output logic            wr_sp_o,
  output logic            wr_pc_o,
  output logic            wr_ex_o,
  output logic            wr_mem_o
);
  logic reg_wr;
  assign reg_wr = wr_i && (sel_i == SEL_REG);

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    assign wr_gpr_o[g] = reg_wr && (tgt_i == 4'(g));
  end

  assign wr_sp_o  = reg_wr && (tgt_i == TGT_SP);
  assign wr_pc_o  = reg_wr && (tgt_i == TGT_PC);
  assign wr_ex_o  = reg_wr && (tgt_i == TGT_EX);
  assign wr_mem_o = wr_i && (sel_i == SEL_MEM);  // literal writes fall away

  // R9: literal targets absorb the write
  p_lit_nowr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_LIT) |-> !(|{wr_gpr_o, wr_sp_o, wr_pc_o, wr_ex_o, wr_mem_o}));
  // R9: never more than one destination
  p_one_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_gpr_o, wr_sp_o, wr_pc_o, wr_ex_o, wr_mem_o}));
  // R9: a real target always receives the write
  p_wr_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i != SEL_LIT) |->
      $countones({wr_gpr_o, wr_sp_o, wr_pc_o, wr_ex_o, wr_mem_o}) == 1);
endmodule

// File: rtl/opd_decoder.sv
module opd_decoder
  import opd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int CW   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dec_i,
  input  logic [5:0]         code_i,
  input  logic [NREG*DW-1:0] regs_i,
  input  logic [DW-1:0]      sp_i,
  input  logic [DW-1:0]      pc_i,
  input  logic [DW-1:0]      ex_i,
  input  logic [DW-1:0]      nw_i,
  input  logic               wr_i,
  output logic [1:0]         sel_o,
  output logic [3:0]         tgt_o,
  output logic [DW-1:0]      addr_o,
  output logic [DW-1:0]      val_o,
  output logic [DW-1:0]      sp_o,
  output logic [DW-1:0]      pc_o,
  output logic [CW-1:0]      cost_o,
  output logic [NREG-1:0]    wr_gpr_o,
  output logic               wr_sp_o,
  output logic               wr_pc_o,
  output logic               wr_ex_o,
  output logic               wr_mem_o
);
  ctl_t          ctl;
  logic [DW-1:0] addr_n, val_n, sp_n, pc_n;
  logic [CW-1:0] cost_n;

  opd_classify u_cls (.code_i(code_i), .ctl_o(ctl));

  opd_eval #(.DW(DW), .NREG(NREG), .CW(CW)) u_eval (
    .ctl_i(ctl), .code_lo_i(code_i[4:0]), .regs_i(regs_i),
    .sp_i(sp_i), .pc_i(pc_i), .ex_i(ex_i), .nw_i(nw_i),
    .addr_o(addr_n), .val_o(val_n), .sp_o(sp_n), .pc_o(pc_n), .cost_o(cost_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= SEL_LIT;
      tgt_o  <= '0;
      addr_o <= '0;
      val_o  <= '0;
      sp_o   <= '0;
      pc_o   <= '0;
      cost_o <= '0;
    end else if (dec_i) begin
      sel_o  <= ctl.sel;
      tgt_o  <= ctl.tgt;
      addr_o <= addr_n;
      val_o  <= val_n;
      sp_o   <= sp_n;
      pc_o   <= pc_n;
      cost_o <= cost_n;
    end
  end

  opd_wsteer #(.NREG(NREG)) u_wst (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel_o), .tgt_i(tgt_o),
    .wr_gpr_o(wr_gpr_o), .wr_sp_o(wr_sp_o), .wr_pc_o(wr_pc_o),
    .wr_ex_o(wr_ex_o), .wr_mem_o(wr_mem_o)
  );

  logic nw_code;
  assign nw_code = (code_i[5:3] == 3'b010) || (code_i == 6'h1e) || (code_i == 6'h1f);

  p_pop_sp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && code_i == 6'h18) |=> (sp_o == $past(sp_i) + 1'b1) && (addr_o == $past(sp_i)));
  p_push_sp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && code_i == 6'h1a) |=> (sp_o == $past(sp_i) - 1'b1) && (addr_o == sp_o));
  p_nw_cost_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && nw_code) |=> (cost_o == CW'(1)) && (pc_o == $past(pc_i) + 1'b1));
  p_no_nw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !nw_code) |=> (cost_o == '0) && (pc_o == $past(pc_i)));
  p_short_lit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && code_i[5]) |=> (sel_o == SEL_LIT) &&
      (val_o == {{(DW-5){1'b0}}, $past(code_i[4:0])}));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_i |=> $stable(sel_o) && $stable(tgt_o) && $stable(addr_o) && $stable(val_o)
               && $stable(sp_o) && $stable(pc_o) && $stable(cost_o));
endmodule

// File: tb/sim_opd_decoder.sv
`timescale 1ns/1ps
module sim_opd_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dec = 1'b0;
  logic [5:0]   code = '0;
  logic [127:0] regs = '0;
  logic [15:0]  sp = '0, pc = '0, ex = '0, nw = '0;
  logic         wr = 1'b0;
  logic [1:0]   sel;
  logic [3:0]   tgt;
  logic [15:0]  addr, val, sp_q, pc_q;
  logic [1:0]   cost;
  logic [7:0]   wg;
  logic         wsp, wpc, wex, wmem;
  logic [15:0]  mem [64];
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_i(dec), .code_i(code), .regs_i(regs),
    .sp_i(sp), .pc_i(pc), .ex_i(ex), .nw_i(nw), .wr_i(wr),
    .sel_o(sel), .tgt_o(tgt), .addr_o(addr), .val_o(val), .sp_o(sp_q), .pc_o(pc_q),
    .cost_o(cost), .wr_gpr_o(wg), .wr_sp_o(wsp), .wr_pc_o(wpc), .wr_ex_o(wex), .wr_mem_o(wmem)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_regs(input logic [15:0] b);
    for (int i = 0; i < 8; i++) regs[i*16 +: 16] = b + 16'(i * 16'h0111);
  endtask

  function automatic logic [15:0] rv(input int i);
    return regs[i*16 +: 16];
  endfunction

  task automatic dec_op(input logic [5:0] c);
    @(negedge clk);
    code = c; dec = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dec = 1'b0;
  endtask

  task automatic wr_probe(output logic [11:0] en);
    @(negedge clk);
    wr = 1'b1;
    #1 en = {wg, wsp, wpc, wex, wmem};
    if (wmem) mem[addr[5:0]] = 16'hA5C3;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sel", 16'(sel), 16'd2);
    chk("R1 tgt", 16'(tgt), 16'd0);
    chk("R1 addr", addr, 16'd0);
    chk("R1 val", val, 16'd0);
    chk("R1 sp", sp_q, 16'd0);
    chk("R1 pc", pc_q, 16'd0);
    chk("R1 cost", 16'(cost), 16'd0);
    chk("R1 wr", 16'({wg, wsp, wpc, wex, wmem}), 16'd0);
  endtask

  task automatic t_direct;
    set_regs(16'h1000); sp = 16'h0200; pc = 16'h0040; ex = 16'hBEEF;
    for (int i = 0; i < 8; i++) begin
      dec_op(6'(i));
      chk("R2 gpr sel", 16'(sel), 16'd0);
      chk("R2 gpr tgt", 16'(tgt), 16'(i));
      chk("R2 gpr val", val, rv(i));
      chk("R8 gpr pc", pc_q, pc);
      chk("R8 gpr sp", sp_q, sp);
    end
    dec_op(6'h1b); chk("R2 sp tgt", 16'(tgt), 16'd8);  chk("R2 sp val", val, sp);
    dec_op(6'h1c); chk("R2 pc tgt", 16'(tgt), 16'd9);  chk("R2 pc val", val, pc);
    chk("R8 pc cost", 16'(cost), 16'd0);
    dec_op(6'h1d); chk("R2 ex tgt", 16'(tgt), 16'd10); chk("R2 ex val", val, ex);
    chk("R2 ex sel", 16'(sel), 16'd0);
  endtask

  task automatic t_indirect;
    set_regs(16'h2300); pc = 16'h0100; sp = 16'h0080;
    for (int i = 0; i < 8; i++) begin
      dec_op(6'h08 + 6'(i));
      chk("R3 sel", 16'(sel), 16'd1);
      chk("R3 addr", addr, rv(i));
      chk("R8 ind pc", pc_q, pc);
      chk("R8 ind cost", 16'(cost), 16'd0);
      chk("R8 ind sp", sp_q, sp);
    end
  endtask

  task automatic t_indexed;
    set_regs(16'h0009); nw = 16'hFFF0; pc = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin
      dec_op(6'h10 + 6'(i));
      chk("R4 sel", 16'(sel), 16'd1);
      chk("R4 addr", addr, 16'(nw + rv(i)));
      chk("R4 pc", pc_q, 16'h0000);
      chk("R4 cost", 16'(cost), 16'd1);
    end
  endtask

  task automatic t_stack;
    pc = 16'h0010;
    sp = 16'h0100; dec_op(6'h18);
    chk("R5 pop sel", 16'(sel), 16'd1);
    chk("R5 pop addr", addr, 16'h0100); chk("R5 pop sp", sp_q, 16'h0101);
    dec_op(6'h19);
    chk("R5 peek addr", addr, 16'h0100); chk("R5 peek sp", sp_q, 16'h0100);
    sp = 16'h0000; dec_op(6'h1a);
    chk("R5 push addr", addr, 16'hFFFF); chk("R5 push sp", sp_q, 16'hFFFF);
    chk("R8 push pc", pc_q, 16'h0010);
    sp = 16'hFFFF; dec_op(6'h18);
    chk("R5 pop wrap addr", addr, 16'hFFFF); chk("R5 pop wrap sp", sp_q, 16'h0000);
  endtask

  task automatic t_nextword;
    nw = 16'h7E21; pc = 16'h0300;
    dec_op(6'h1e);
    chk("R6 mem sel", 16'(sel), 16'd1); chk("R6 mem addr", addr, nw);
    chk("R6 mem pc", pc_q, 16'h0301);   chk("R6 mem cost", 16'(cost), 16'd1);
    dec_op(6'h1f);
    chk("R6 lit sel", 16'(sel), 16'd2); chk("R6 lit val", val, nw);
    chk("R6 lit pc", pc_q, 16'h0301);   chk("R6 lit cost", 16'(cost), 16'd1);
  endtask

  task automatic t_short;
    pc = 16'h0500; nw = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      dec_op(6'h20 + 6'(i));
      chk("R7 sel", 16'(sel), 16'd2);
      chk("R7 val", val, 16'(i));
      chk("R8 lit pc", pc_q, 16'h0500);
    end
  endtask

  task automatic t_hold;
    logic [15:0] a0;
    sp = 16'h0042; dec_op(6'h1a);
    a0 = addr;
    @(negedge clk);
    code = 6'h1f; sp = 16'h9999; pc = 16'h1234; nw = 16'h5555; set_regs(16'h7000);
    repeat (3) @(negedge clk);
    chk("R10 sel", 16'(sel), 16'd1);
    chk("R10 addr", addr, a0);
    chk("R10 sp", sp_q, 16'h0041);
    chk("R10 cost", 16'(cost), 16'd0);
  endtask

  task automatic t_write;
    logic [11:0] en;
    set_regs(16'h0300);
    for (int i = 0; i < 8; i++) begin
      dec_op(6'(i)); wr_probe(en);
      chk("R9 gpr", 16'(en), 16'({8'(1 << i), 4'b0000}));
    end
    dec_op(6'h1b); wr_probe(en); chk("R9 sp", 16'(en), 16'h0008);
    dec_op(6'h1c); wr_probe(en); chk("R9 pc", 16'(en), 16'h0004);
    dec_op(6'h1d); wr_probe(en); chk("R9 ex", 16'(en), 16'h0002);
    dec_op(6'h25); wr_probe(en); chk("R9 short lit", 16'(en), 16'h0000);
    dec_op(6'h1f); wr_probe(en); chk("R9 nw lit", 16'(en), 16'h0000);
    dec_op(6'h1f); chk("R9 lit val kept", val, nw);
    // push writes, pop reads the same word
    sp = 16'h0020; dec_op(6'h1a); wr_probe(en); chk("R9 mem", 16'(en), 16'h0001);
    sp = sp_q; dec_op(6'h18);
    chk("R5 push-pop addr", addr, 16'h001F);
    chk("R5 push-pop data", mem[addr[5:0]], 16'hA5C3);
    chk("R5 push-pop sp", sp_q, 16'h0020);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_direct;
    t_indirect;
    t_indexed;
    t_stack;
    t_nextword;
    t_short;
    t_hold;
    t_write;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule